// File: doc/BRIEF.md
# Configuration EEPROM Register Preload Parser

After a hard reset, this block reads the byte stream that a serial transport fetches from a configuration EEPROM. The stream must open with a fixed three-byte marker. A chain of seven-byte records follows, and each record turns into one 32-bit memory-mapped write with a four-lane byte-enable mask. A terminal frame ends the chain. Its first three bytes are zero, and its last four bytes hold a CRC-32 taken over everything that came before it.

Each record carries an 18-bit word offset and a window-select bit. The parser forms a full 32-bit address from three parts, high to low: a 12-bit base taken from one of two base inputs, then the offset, then two zero bits. The two low bits are zero because the byte enables pick the lanes. The parser holds off its byte input while a write waits for acknowledge. Only a matching CRC raises the done flag. A bad marker, a CRC mismatch, a malformed frame or an address wrap reported by the transport raises a sticky hard-reset request, and the parser then halts until the next reset.

Top module: `cfg_preload_parser`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done` is 0, `hreset_req` is 0, `wr_req` is 0 and `in_ready` is 1.
- R2: The first three accepted bytes must be 0xAA, then 0x55, then 0xAA. If any of them differs, `hreset_req` is 1 in the cycle after that byte is accepted.
- R3: Record byte 0 is laid out as follows. Bit 7 is the window select. Bits 6..3 are the byte enables, and they map to `wr_be[3:0]` with bit 6 driving `wr_be[3]`, the lane of `wr_data[31:24]`. Bit 2 is the continue flag. Bits 1..0 are offset bits 17..16. Bytes 1 and 2 carry offset bits 15..8 and 7..0. Bytes 3 to 6 form `wr_data`, most significant byte first.
- R4: `wr_addr` = {base, 18-bit offset, 2'b00}. The base is `base_alt` when the window-select bit is 1 and `base_norm` when it is 0.
- R5: Each record produces exactly one write. `wr_req` rises in the cycle after the seventh record byte is accepted. It stays high with stable address, data and enables until a cycle in which `wr_ack` is 1, and it is low in the next cycle. `in_ready` is 0 while `wr_req` is 1.
- R6: A frame whose first three bytes are all zero is the terminal frame. It issues no write, and its bytes 3 to 6 are the expected CRC, most significant byte first.
- R7: The CRC is CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and no final inversion, processed MSB first. It covers the marker, every record and the three zero bytes of the terminal frame. When the received CRC matches, `done` is 1 in the cycle after the last CRC byte is accepted.
- R8: When the received CRC does not match, `hreset_req` is 1 in the cycle after the last CRC byte is accepted, and `done` stays 0.
- R9: A frame with the continue flag clear whose first three bytes are not all zero issues no write. `hreset_req` is 1 in the cycle after its seventh byte is accepted.
- R10: When `wrap_seen` is 1 in any cycle before completion, `hreset_req` is 1 in the next cycle, and a pending write is withdrawn (`wr_req` goes to 0).
- R11: `done` and `hreset_req` are sticky until reset and never both 1. While either is 1, `in_ready` and `wr_req` stay 0, and `wrap_seen` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | EEPROM byte available |
| in_byte | input | 8 | EEPROM byte |
| in_ready | output | 1 | Parser accepts the byte this cycle |
| wrap_seen | input | 1 | Transport wrapped to the first EEPROM address |
| base_norm | input | 12 | Base for window-select 0 |
| base_alt | input | 12 | Base for window-select 1 |
| wr_req | output | 1 | Write request pending |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Write byte enables |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | Stream completed with a matching CRC |
| hreset_req | output | 1 | Sticky hard-reset request |

## Verification
All results are due one clock after their cause, because every output comes from a register that is loaded on the same edge that accepts the deciding byte. That byte can be the seventh byte of a record (the write request follows), the last CRC byte (done or the reset request follows), a bad marker byte (the reset request follows), or a cycle with `wrap_seen` high (the reset request follows). The bench drives bytes at the falling edge and waits for the rising edge that accepts them. It samples at the next falling edge, so every check falls exactly one edge after its stimulus. Write acknowledges come from a responder with a selectable delay, and the bench observes the stall with the request still open.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int PRE_LEN  = 3;
    localparam int REC_LEN  = 7;
    localparam int BYTE_W   = 8;
    localparam int BASE_W   = 12;
    localparam int OFF_W    = 18;
    localparam int AW       = 32;
    localparam int DW       = 32;
    localparam int BEW      = DW / BYTE_W;
    localparam int IDX_W    = $clog2(REC_LEN);
    localparam int BUF_LEN  = REC_LEN - 1;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_FRM,
        ST_WR,
        ST_DONE,
        ST_ERR
    } cfgp_state_e;

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [BEW-1:0] be;
    } cfgp_txn_t;

    function automatic logic [BYTE_W-1:0] marker_byte(input logic [IDX_W-1:0] pos);
        return (pos == IDX_W'(1)) ? 8'h55 : 8'hAA;
    endfunction

    function automatic logic [31:0] crc32_step(input logic [31:0] cur,
                                               input logic [BYTE_W-1:0] din);
        logic [31:0] r;
        r = cur ^ {din, 24'h0};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[31] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

    function automatic cfgp_txn_t make_txn(input logic [BYTE_W-1:0] hdr,
                                           input logic [BYTE_W-1:0] off_mid,
                                           input logic [BYTE_W-1:0] off_lo,
                                           input logic [DW-1:0]     data,
                                           input logic [BASE_W-1:0] b_norm,
                                           input logic [BASE_W-1:0] b_alt);
        cfgp_txn_t t;
        t.addr = {(hdr[7] ? b_alt : b_norm), hdr[1:0], off_mid, off_lo, 2'b00};
        t.data = data;
        t.be   = hdr[6:3];
        return t;
    endfunction

endpackage

// File: rtl/cfgp_crc32.sv
module cfgp_crc32
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [31:0]       crc_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crc_o <= CRC_INIT;
        end else if (en) begin
            crc_o <= crc32_step(crc_o, din);
        end
    end
endmodule

// File: rtl/cfgp_frame_buf.sv
module cfgp_frame_buf #(
    parameter int LANES = 6,
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [SEL_W-1:0]          sel,
    input  logic [W-1:0]              din,
    output logic [LANES-1:0][W-1:0]   q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (we && sel == SEL_W'(g)) begin
                q[g] <= din;
            end
        end
    end
endmodule

// File: rtl/cfg_preload_parser.sv
module cfg_preload_parser
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    input  logic              wrap_seen,
    input  logic [11:0]       base_norm,
    input  logic [11:0]       base_alt,
    output logic              wr_req,
    output logic [31:0]       wr_addr,
    output logic [31:0]       wr_data,
    output logic [3:0]        wr_be,
    input  logic              wr_ack,
    output logic              done,
    output logic              hreset_req
);
    localparam logic [IDX_W-1:0] LAST_PRE = IDX_W'(PRE_LEN - 1);
    localparam logic [IDX_W-1:0] LAST_REC = IDX_W'(REC_LEN - 1);
    localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(2);

    cfgp_state_e               state;
    logic [IDX_W-1:0]          idx;
    logic                      zero_run;
    logic                      term;
    cfgp_txn_t                 txn_q;
    logic                      accept;
    logic                      crc_en;
    logic                      buf_we;
    logic [31:0]               crc_val;
    logic [BUF_LEN-1:0][7:0]   fb;
    logic [31:0]               rx_crc;
    logic                      hdr_zero_now;

    assign in_ready = (state == ST_PRE) || (state == ST_FRM);
    assign accept   = in_valid && in_ready;
    assign buf_we   = accept && (state == ST_FRM);
    assign crc_en   = accept && !((state == ST_FRM) && term && (idx > HDR_END));
    assign rx_crc   = {fb[3], fb[4], fb[5], in_byte};
    assign hdr_zero_now = zero_run && (in_byte == 8'h00);

    cfgp_crc32 crc_i (
        .clk   (clk),
        .rst   (rst),
        .en    (crc_en),
        .din   (in_byte),
        .crc_o (crc_val)
    );

    cfgp_frame_buf #(
        .LANES (BUF_LEN),
        .W     (BYTE_W),
        .SEL_W (IDX_W)
    ) fbuf_i (
        .clk (clk),
        .rst (rst),
        .we  (buf_we),
        .sel (idx),
        .din (in_byte),
        .q   (fb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PRE;
            idx      <= '0;
            zero_run <= 1'b1;
            term     <= 1'b0;
            txn_q    <= '0;
        end else begin
            unique case (state)
                ST_PRE: begin
                    if (wrap_seen) begin
                        state <= ST_ERR;
                    end else if (accept) begin
                        if (in_byte != marker_byte(idx)) begin
                            state <= ST_ERR;
                        end else if (idx == LAST_PRE) begin
                            state <= ST_FRM;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_FRM: begin
                    if (wrap_seen) begin
                        state <= ST_ERR;
                    end else if (accept) begin
                        if (idx == LAST_REC) begin
                            idx      <= '0;
                            zero_run <= 1'b1;
                            term     <= 1'b0;
                            if (term) begin
                                state <= (rx_crc == crc_val) ? ST_DONE : ST_ERR;
                            end else if (!fb[0][2]) begin
                                state <= ST_ERR;
                            end else begin
                                txn_q <= make_txn(fb[0], fb[1], fb[2],
                                                  {fb[3], fb[4], fb[5], in_byte},
                                                  base_norm, base_alt);
                                state <= ST_WR;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                            if (idx <= HDR_END) begin
                                zero_run <= hdr_zero_now;
                            end
                            if (idx == HDR_END) begin
                                term <= hdr_zero_now;
                            end
                        end
                    end
                end
                ST_WR: begin
                    if (wrap_seen) begin
                        state <= ST_ERR;
                    end else if (wr_ack) begin
                        state <= ST_FRM;
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
        end
    end

    assign wr_req     = (state == ST_WR);
    assign wr_addr    = txn_q.addr;
    assign wr_data    = txn_q.data;
    assign wr_be      = txn_q.be;
    assign done       = (state == ST_DONE);
    assign hreset_req = (state == ST_ERR);

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        wrap_seen,
    input logic        wr_req,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic [3:0]  wr_be,
    input logic        wr_ack,
    input logic        done,
    input logic        hreset_req
);
    // R5: an open request keeps its fields until acknowledged
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack && !wrap_seen |=> wr_req && $stable(wr_addr)
                                           && $stable(wr_data) && $stable(wr_be));

    // R5: acknowledge closes the request
    a_r5_ack_drop: assert property (@(posedge clk) disable iff (rst)
        wr_req && wr_ack |=> !wr_req);

    // R5: input stalled while a write is open
    a_r5_stall: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !in_ready);

    // R10: a wrap before completion forces the reset request
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        wrap_seen && !done |=> hreset_req);

    // R11: sticky outcomes
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        hreset_req |=> hreset_req);

    // R11: outcomes exclusive and quiet
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && hreset_req));

    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        (done || hreset_req) |-> !wr_req && !in_ready);
endmodule

bind cfg_preload_parser cfgp_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .wrap_seen  (wrap_seen),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .wr_ack     (wr_ack),
    .done       (done),
    .hreset_req (hreset_req)
);

// File: tb/cfg_preload_parser_tb_top.sv
`timescale 1ns/1ps
module cfg_preload_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        wrap_seen = 1'b0;
    logic [11:0] base_norm = 12'hE00;
    logic [11:0] base_alt  = 12'h7A5;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        wr_ack = 1'b0;
    logic        done;
    logic        hreset_req;

    always #2.5 clk = ~clk;

    cfg_preload_parser dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .wrap_seen(wrap_seen), .base_norm(base_norm),
        .base_alt(base_alt), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .wr_ack(wr_ack), .done(done),
        .hreset_req(hreset_req)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  strm [0:127];
    int          n_strm;
    logic [31:0] exp_addr [0:15];
    logic [31:0] exp_data [0:15];
    logic [3:0]  exp_be   [0:15];
    int          n_exp;
    logic [31:0] got_addr [0:15];
    logic [31:0] got_data [0:15];
    logic [3:0]  got_be   [0:15];
    int          n_wr;
    int          ack_lat = 2;
    int          lat_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // write responder
    initial begin
        forever begin
            @(negedge clk);
            if (wr_ack) begin
                wr_ack  = 1'b0;
                lat_cnt = 0;
            end else if (wr_req) begin
                if (lat_cnt >= ack_lat) begin
                    if (n_wr < 16) begin
                        got_addr[n_wr] = wr_addr;
                        got_data[n_wr] = wr_data;
                        got_be[n_wr]   = wr_be;
                    end
                    n_wr++;
                    wr_ack = 1'b1;
                end else begin
                    lat_cnt++;
                end
            end else begin
                lat_cnt = 0;
            end
        end
    end

    function automatic logic [31:0] ref_crc(input int upto);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < upto; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fbk;
                fbk = c[31] ^ strm[i][b];
                c = {c[30:0], 1'b0};
                if (fbk) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    task automatic push(input logic [7:0] b);
        strm[n_strm] = b;
        n_strm++;
    endtask

    task automatic push_marker();
        push(8'hAA); push(8'h55); push(8'hAA);
    endtask

    task automatic push_rec(input bit win, input logic [3:0] be, input bit cont,
                            input logic [17:0] off, input logic [31:0] dat);
        push({win, be, cont, off[17:16]});
        push(off[15:8]); push(off[7:0]);
        push(dat[31:24]); push(dat[23:16]); push(dat[15:8]); push(dat[7:0]);
        exp_addr[n_exp] = {(win ? base_alt : base_norm), off, 2'b00};
        exp_data[n_exp] = dat;
        exp_be[n_exp]   = be;
        n_exp++;
    endtask

    task automatic push_term(input bit corrupt);
        logic [31:0] c;
        push(8'h00); push(8'h00); push(8'h00);
        c = ref_crc(n_strm);
        if (corrupt) c = c ^ 32'h0000_0100;
        push(c[31:24]); push(c[23:16]); push(c[15:8]); push(c[7:0]);
    endtask

    task automatic send_byte(input logic [7:0] b);
        int guard;
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        guard = 0;
        while (!in_ready && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
    endtask

    task automatic play(input int from, input int upto);
        for (int i = from; i < upto; i++) send_byte(strm[i]);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; wrap_seen = 1'b0;
        n_strm = 0; n_exp = 0; n_wr = 0; ack_lat = 2;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_writes(input string req);
        chk(n_wr == n_exp, req, "write count", n_wr, n_exp);
        for (int i = 0; i < n_exp && i < n_wr; i++) begin
            chk(got_addr[i] == exp_addr[i], "R4", "wr_addr", got_addr[i], exp_addr[i]);
            chk(got_data[i] == exp_data[i], "R3", "wr_data", got_data[i], exp_data[i]);
            chk(got_be[i] == exp_be[i], "R3", "wr_be", {28'h0, got_be[i]}, {28'h0, exp_be[i]});
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(!done && !hreset_req && !wr_req && in_ready, "R1", "reset outputs",
            {done, hreset_req, wr_req, in_ready}, 32'h1);
    endtask

    task automatic t_good_stream();
        do_reset();
        push_marker();
        push_rec(1'b0, 4'b1111, 1'b1, 18'h2_1234, 32'hDEAD_BEEF);
        push_rec(1'b1, 4'b1000, 1'b1, 18'h0_00FF, 32'h1122_3344);
        push_rec(1'b0, 4'b0011, 1'b1, 18'h3_FFFF, 32'h0000_A55A);
        push_term(1'b0);
        play(0, n_strm);
        chk(done == 1'b1, "R7", "done after good CRC", done, 1);
        chk(hreset_req == 1'b0, "R7", "no reset request", hreset_req, 0);
        chk_writes("R5");
        // R11: wrap and further input ignored after done
        wrap_seen = 1'b1; in_valid = 1'b1; in_byte = 8'hAA;
        repeat (3) @(negedge clk);
        chk(done && !hreset_req && !in_ready, "R11", "done holds, wrap ignored",
            {done, hreset_req, in_ready}, 32'h4);
        wrap_seen = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_stall();
        do_reset();
        ack_lat = 6;
        push_marker();
        push_rec(1'b1, 4'b0100, 1'b1, 18'h1_0203, 32'hCAFE_F00D);
        play(0, n_strm - 1);
        send_byte(strm[n_strm - 1]);
        @(negedge clk);
        in_valid = 1'b0;
        chk(wr_req == 1'b1, "R5", "wr_req one cycle after 7th byte", wr_req, 1);
        chk(in_ready == 1'b0, "R5", "input stalled while pending", in_ready, 0);
        repeat (10) @(negedge clk);
        chk(wr_req == 1'b0 && in_ready == 1'b1, "R5", "released after ack",
            {wr_req, in_ready}, 32'h1);
        push_term(1'b0);
        play(10, n_strm);
        chk(done == 1'b1, "R6", "terminal frame completes", done, 1);
        chk_writes("R5");
    endtask

    task automatic t_empty_chain();
        do_reset();
        push_marker();
        push_term(1'b0);
        play(0, n_strm);
        chk(done == 1'b1, "R6", "terminal only, done", done, 1);
        chk(n_wr == 0, "R6", "terminal frame writes nothing", n_wr, 0);
    endtask

    task automatic t_bad_marker();
        do_reset();
        push(8'hAA); push(8'h54);
        play(0, n_strm);
        chk(hreset_req == 1'b1, "R2", "bad second marker byte", hreset_req, 1);
        chk(done == 1'b0, "R2", "no done", done, 0);
        in_valid = 1'b1; in_byte = 8'hAA;
        repeat (4) @(negedge clk);
        chk(!in_ready && hreset_req && n_wr == 0, "R11", "halted after error",
            {in_ready, hreset_req}, 32'h1);
        in_valid = 1'b0;
    endtask

    task automatic t_bad_crc();
        do_reset();
        push_marker();
        push_rec(1'b0, 4'b1111, 1'b1, 18'h0_0010, 32'h8765_4321);
        push_term(1'b1);
        play(0, n_strm);
        chk(hreset_req == 1'b1, "R8", "CRC mismatch", hreset_req, 1);
        chk(done == 1'b0, "R8", "no done on mismatch", done, 0);
        chk_writes("R8");
    endtask

    task automatic t_no_cont();
        do_reset();
        push_marker();
        push(8'h78); push(8'h12); push(8'h34);
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        play(0, n_strm);
        chk(hreset_req == 1'b1, "R9", "clear continue, nonzero header", hreset_req, 1);
        chk(n_wr == 0 && !wr_req, "R9", "no write issued", n_wr, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        push_marker();
        push_rec(1'b0, 4'b1111, 1'b1, 18'h0_0004, 32'h0);
        play(0, 6);
        @(negedge clk);
        wrap_seen = 1'b1;
        @(negedge clk);
        wrap_seen = 1'b0;
        chk(hreset_req == 1'b1, "R10", "wrap mid-frame", hreset_req, 1);
        // wrap while a write is pending
        do_reset();
        ack_lat = 40;
        push_marker();
        push_rec(1'b1, 4'b0001, 1'b1, 18'h0_0008, 32'h5);
        play(0, n_strm);
        chk(wr_req == 1'b1, "R10", "write pending before wrap", wr_req, 1);
        wrap_seen = 1'b1;
        @(negedge clk);
        wrap_seen = 1'b0;
        chk(hreset_req && !wr_req, "R10", "pending write withdrawn",
            {hreset_req, wr_req}, 32'h2);
        repeat (45) @(negedge clk);
        chk(n_wr == 0, "R10", "no write acknowledged", n_wr, 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_good_stream();
        t_stall();
        t_empty_chain();
        t_bad_marker();
        t_bad_crc();
        t_no_cont();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule